// File: doc/BRIEF.md
# Row-Packed Element Store with Merged Writes

The block stores a small two-dimensional array of fixed-width elements. Each memory word holds every element of one row side by side, so a consumer can fetch a complete row in a single access. That gives the read side its full width every cycle. The storage has no per-lane write enable, so an element update must read the containing word, splice the new element into its lane, and write the whole word back.

Element writes enter through a valid/ready port. The accepting edge latches the request. In the next cycle the containing row is read. In the cycle after that the merged word is written back, and the write port holds ready low for that cycle. Two writes may therefore be accepted on consecutive edges. After such a pair the port stalls for two cycles, so sustained element throughput is capped at half the clock rate.

The row read port is separate and has a fixed latency of one cycle. Two hazards are resolved inside the block. A row read issued during a write-back to the same row returns the merged word. A write that reaches its read cycle while an earlier write to the same row is still being written back builds on the merged word rather than on the stale stored row.

Top module: `prw_mem`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `wr_ready` is 1 and `rd_valid` is 0. Every row reads as all zeros after reset.
- R2: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. In that cycle `rd_data` carries the addressed row.
- R3: The element in column c of a row occupies bits [EW*c+EW-1 : EW*c] of the row word, for c from 0 to COLS-1. An element write leaves every other lane of the row unchanged.
- R4: An element write accepted at the edge ending cycle T is stored at the edge ending cycle T+2. A row read issued in cycle T+1 still returns the previous contents.
- R5: `wr_ready` is low in cycle T+2 for a write accepted at the edge ending cycle T. When three writes are offered back to back from an idle state, the first two are accepted without stalls and the third waits exactly two cycles.
- R6: A row read issued in the cycle in which a write-back to the same row takes place returns the merged, updated word.
- R7: Two element writes to different lanes of the same row, accepted on consecutive edges, both land in the row.
- R8: Two element writes to the same lane of the same row, accepted on consecutive edges, leave the value of the later one.
- R9: A write offered while `wr_ready` is low is not accepted and does not change any row.
- R10: Element writes never disturb rows other than the one they address, under arbitrary mixes of rows, lanes and gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Row read request |
| rd_row | input | RAW ($clog2(ROWS)) | Row to read |
| rd_valid | output | 1 | Row data is valid this cycle |
| rd_data | output | COLS*EW | Packed row, column c in lane c |
| wr_valid | input | 1 | Element write offered |
| wr_ready | output | 1 | Element write can be accepted this cycle |
| wr_row | input | RAW | Row of the element write |
| wr_col | input | CAW ($clog2(COLS)) | Column (lane) of the element write |
| wr_elem | input | EW | Element value |

## Verification
The bench builds the block with its default geometry: 8 rows, 8 columns and 16-bit elements. At that geometry the lane select spans its full three-bit range, so the top lane at bits 127:112 and the bottom lane at bits 15:0 are both exercised. Every row address is decodable, so writes spread over all rows show that no row leaks into another. The geometry is small enough that back-to-back pairs, writes blocked by a stall, and reads aligned to the exact write-back cycle can be placed cycle by cycle against a full shadow of the array.

// File: rtl/prw_pkg.sv
package prw_pkg;

    // Default geometry of the packed-row store
    localparam int DEF_ROWS = 8;
    localparam int DEF_COLS = 8;
    localparam int DEF_EW   = 16;

    // Where a captured row word comes from: the stored array, or the
    // word that is being written back in the same cycle.
    typedef enum logic {
        SRC_ARRAY = 1'b0,
        SRC_FWD   = 1'b1
    } word_src_e;

endpackage

// File: rtl/prw_row_store.sv
module prw_row_store #(
    parameter int ROWS = 8,
    parameter int WW   = 128,
    parameter int RAW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RAW-1:0] waddr,
    input  logic [WW-1:0]  wdata,
    input  logic [RAW-1:0] ra_addr,
    output logic [WW-1:0]  ra_data,
    input  logic [RAW-1:0] rb_addr,
    output logic [WW-1:0]  rb_data
);

    logic [WW-1:0] row_q [ROWS];

    // One full-width register per row; only whole words are ever written.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                row_q[r] <= '0;
            end else if (we && (waddr == RAW'(r))) begin
                row_q[r] <= wdata;
            end
        end
    end

    // Two independent read ports: one for the merge sequencer,
    // one for the wide consumer port.
    assign ra_data = row_q[ra_addr];
    assign rb_data = row_q[rb_addr];

endmodule

// File: rtl/prw_rmw_pipe.sv
module prw_rmw_pipe
    import prw_pkg::*;
#(
    parameter int COLS = 8,
    parameter int EW   = 16,
    parameter int RAW  = 3,
    parameter int CAW  = 3,
    parameter int WW   = COLS * EW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [RAW-1:0] req_row,
    input  logic [CAW-1:0] req_col,
    input  logic [EW-1:0]  req_elem,
    output logic [RAW-1:0] arr_addr,
    input  logic [WW-1:0]  arr_word,
    output logic           wb_en,
    output logic [RAW-1:0] wb_row,
    output logic [WW-1:0]  wb_word
);

    // Read stage: the request latched at the accepting edge
    logic           rs_vld;
    logic [RAW-1:0] rs_row;
    logic [CAW-1:0] rs_col;
    logic [EW-1:0]  rs_elem;

    // Merge stage: the base word plus the lane to replace
    logic           ms_vld;
    logic [RAW-1:0] ms_row;
    logic [CAW-1:0] ms_col;
    logic [EW-1:0]  ms_elem;
    logic [WW-1:0]  ms_base;

    logic           accept;
    word_src_e      base_src;
    logic [WW-1:0]  base_next;
    logic [WW-1:0]  merged;

    // The port stalls only while a write-back is in progress
    assign req_ready = !ms_vld;
    assign accept    = req_valid && req_ready;

    // The read stage addresses the array for the row it will update
    assign arr_addr = rs_row;

    // A write-back to the same row lands at the very edge that captures
    // the base word, so the captured word is taken from the merge result.
    always_comb begin
        if (ms_vld && (ms_row == rs_row)) begin
            base_src = SRC_FWD;
        end else begin
            base_src = SRC_ARRAY;
        end
    end

    assign base_next = (base_src == SRC_FWD) ? merged : arr_word;

    // Lane splice: only the addressed lane takes the new element
    for (genvar c = 0; c < COLS; c++) begin : g_lane
        assign merged[c*EW +: EW] = (ms_col == CAW'(c)) ? ms_elem
                                                        : ms_base[c*EW +: EW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_vld <= 1'b0;
            ms_vld <= 1'b0;
        end else begin
            rs_vld <= accept;
            ms_vld <= rs_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rs_row  <= req_row;
            rs_col  <= req_col;
            rs_elem <= req_elem;
        end
        if (rs_vld) begin
            ms_row  <= rs_row;
            ms_col  <= rs_col;
            ms_elem <= rs_elem;
            ms_base <= base_next;
        end
    end

    assign wb_en   = ms_vld;
    assign wb_row  = ms_row;
    assign wb_word = merged;

endmodule

// File: rtl/prw_wide_reader.sv
module prw_wide_reader
    import prw_pkg::*;
#(
    parameter int WW  = 128,
    parameter int RAW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [RAW-1:0] rd_row,
    input  logic [WW-1:0]  arr_word,
    input  logic           wb_en,
    input  logic [RAW-1:0] wb_row,
    input  logic [WW-1:0]  wb_word,
    output logic           rd_valid,
    output logic [WW-1:0]  rd_data
);

    word_src_e     src;
    logic [WW-1:0] pick;

    // A read that coincides with a write-back of its row sees the new word
    always_comb begin
        if (wb_en && (wb_row == rd_row)) begin
            src = SRC_FWD;
        end else begin
            src = SRC_ARRAY;
        end
    end

    assign pick = (src == SRC_FWD) ? wb_word : arr_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= pick;
        end
    end

endmodule

// File: rtl/prw_mem.sv
module prw_mem #(
    parameter  int ROWS = prw_pkg::DEF_ROWS,
    parameter  int COLS = prw_pkg::DEF_COLS,
    parameter  int EW   = prw_pkg::DEF_EW,
    localparam int WW   = COLS * EW,
    localparam int RAW  = $clog2(ROWS),
    localparam int CAW  = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [RAW-1:0] rd_row,
    output logic           rd_valid,
    output logic [WW-1:0]  rd_data,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [RAW-1:0] wr_row,
    input  logic [CAW-1:0] wr_col,
    input  logic [EW-1:0]  wr_elem
);

    logic [RAW-1:0] seq_addr;
    logic [WW-1:0]  seq_word;
    logic [WW-1:0]  cons_word;
    logic           wb_en;
    logic [RAW-1:0] wb_row;
    logic [WW-1:0]  wb_word;

    prw_row_store #(
        .ROWS (ROWS),
        .WW   (WW),
        .RAW  (RAW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_en),
        .waddr   (wb_row),
        .wdata   (wb_word),
        .ra_addr (seq_addr),
        .ra_data (seq_word),
        .rb_addr (rd_row),
        .rb_data (cons_word)
    );

    prw_rmw_pipe #(
        .COLS (COLS),
        .EW   (EW),
        .RAW  (RAW),
        .CAW  (CAW),
        .WW   (WW)
    ) u_rmw (
        .clk       (clk),
        .rst       (rst),
        .req_valid (wr_valid),
        .req_ready (wr_ready),
        .req_row   (wr_row),
        .req_col   (wr_col),
        .req_elem  (wr_elem),
        .arr_addr  (seq_addr),
        .arr_word  (seq_word),
        .wb_en     (wb_en),
        .wb_row    (wb_row),
        .wb_word   (wb_word)
    );

    prw_wide_reader #(
        .WW  (WW),
        .RAW (RAW)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_row   (rd_row),
        .arr_word (cons_word),
        .wb_en    (wb_en),
        .wb_row   (wb_row),
        .wb_word  (wb_word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/prw_mem_chk.sv
module prw_mem_chk #(
    parameter  int ROWS = 8,
    parameter  int COLS = 8,
    parameter  int EW   = 16,
    localparam int WW   = COLS * EW,
    localparam int RAW  = $clog2(ROWS),
    localparam int CAW  = $clog2(COLS)
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_en,
    input logic [RAW-1:0] rd_row,
    input logic           rd_valid,
    input logic [WW-1:0]  rd_data,
    input logic           wr_valid,
    input logic           wr_ready,
    input logic [RAW-1:0] wr_row,
    input logic [CAW-1:0] wr_col,
    input logic [EW-1:0]  wr_elem
);

    logic acc;
    assign acc = wr_valid && wr_ready;

    // R1
    reset_exit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_ready && !rd_valid));

    // R2
    read_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R2
    read_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R5
    merge_cycle_stall_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> ##2 !wr_ready);

    // R5
    pair_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc) && !$past(rst)) |=> !wr_ready);

endmodule

bind prw_mem prw_mem_chk #(
    .ROWS (ROWS),
    .COLS (COLS),
    .EW   (EW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_row   (rd_row),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_row   (wr_row),
    .wr_col   (wr_col),
    .wr_elem  (wr_elem)
);

// File: tb/tb_prw_mem.sv
module tb_prw_mem;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int EW   = 16;
    localparam int WW   = COLS * EW;
    localparam int RAW  = $clog2(ROWS);
    localparam int CAW  = $clog2(COLS);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rd_en = 1'b0;
    logic [RAW-1:0] rd_row = '0;
    logic           rd_valid;
    logic [WW-1:0]  rd_data;
    logic           wr_valid = 1'b0;
    logic           wr_ready;
    logic [RAW-1:0] wr_row = '0;
    logic [CAW-1:0] wr_col = '0;
    logic [EW-1:0]  wr_elem = '0;

    always #10 clk = ~clk;

    prw_mem #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) dut (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_row   (rd_row),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_elem  (wr_elem)
    );

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    logic [WW-1:0] shadow [ROWS];
    logic [WW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic chk(input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd_issue_exp(input int row, input logic [WW-1:0] exp,
                                input string req);
        rd_en  = 1'b1;
        rd_row = RAW'(row);
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic rd_issue(input int row, input string req);
        rd_issue_exp(row, shadow[row], req);
    endtask

    task automatic idle(input int n);
        wr_valid = 1'b0;
        rd_en    = 1'b0;
        repeat (n) tick();
    endtask

    // Offer one element write and hold it until accepted; shadow follows R3.
    task automatic wr(input int row, input int col, input logic [EW-1:0] val,
                      output int stalls);
        wr_valid = 1'b1;
        wr_row   = RAW'(row);
        wr_col   = CAW'(col);
        wr_elem  = val;
        stalls   = 0;
        while (!wr_ready) begin
            stalls++;
            tick();
        end
        shadow[row][col*EW +: EW] = val;
        tick();
    endtask

    // Scoreboard monitor: samples just after each edge, inputs still held
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R2 valid", WW'(rd_valid), WW'(rd_en));
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected data", WW'(1), WW'(0));
                end else begin
                    chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0, s1, s2;
        logic [WW-1:0] old_word;
        logic [WW-1:0] snap;
        for (int r = 0; r < ROWS; r++) shadow[r] = '0;

        repeat (3) tick();
        rst = 1'b0;
        // R1: state right after reset
        chk("R1 ready", WW'(wr_ready), WW'(1));
        chk("R1 rd_valid", WW'(rd_valid), WW'(0));
        for (int r = 0; r < ROWS; r++) begin
            rd_issue(r, "R1 zero row");
            tick();
        end
        idle(2);

        // R3: fill each lane of row 1 with a distinct value, read back
        for (int c = 0; c < COLS; c++) begin
            wr(1, c, EW'(16'h1000 + c * 16'h0111), s0);
        end
        idle(3);
        rd_issue(1, "R3 lanes");
        tick();
        idle(1);
        wr(1, 4, 16'hC0DE, s0);
        idle(3);
        rd_issue(1, "R3 other lanes kept");
        tick();
        idle(2);

        // R5 / R7: three offers back to back into row 2
        wr(2, 0, 16'hA001, s0);
        wr(2, 1, 16'hA002, s1);
        wr(2, 7, 16'hA003, s2);
        chk("R5 first stalls", WW'(s0), WW'(0));
        chk("R5 second stalls", WW'(s1), WW'(0));
        chk("R5 third stalls", WW'(s2), WW'(2));
        idle(3);
        rd_issue(2, "R7 same row pair");
        tick();
        idle(2);

        // R9: offer during the stall window, must be dropped
        wr(5, 0, 16'h5555, s0);
        wr(5, 1, 16'h6666, s0);
        wr_row  = RAW'(5);
        wr_col  = CAW'(2);
        wr_elem = 16'hBEEF;
        chk("R5 ready low cycle A", WW'(wr_ready), WW'(0));
        tick();
        chk("R5 ready low cycle B", WW'(wr_ready), WW'(0));
        tick();
        wr_valid = 1'b0;
        chk("R9 ready back", WW'(wr_ready), WW'(1));
        idle(3);
        rd_issue(5, "R9 blocked write ignored");
        tick();
        idle(2);

        // R8: same lane twice, later wins
        wr(6, 3, 16'hAAAA, s0);
        wr(6, 3, 16'hBBBB, s0);
        idle(3);
        rd_issue(6, "R8 later value");
        tick();
        idle(2);

        // R4 / R6: reads placed on the read cycle and the write-back cycle
        old_word = shadow[4];
        wr(4, 2, 16'h1234, s0);
        wr_valid = 1'b0;
        rd_issue_exp(4, old_word, "R4 before write-back");
        tick();
        rd_issue(4, "R6 forwarded on write-back");
        tick();
        idle(3);

        // R6 / R7: pair into row 7, read on both write-back cycles
        wr(7, 0, 16'h0F0F, s0);
        snap = shadow[7];
        wr(7, 1, 16'hF0F0, s0);
        wr_valid = 1'b0;
        rd_issue_exp(7, snap, "R6 first write-back");
        tick();
        rd_issue(7, "R6 second write-back");
        tick();
        idle(3);

        // R10: random writes over all rows and lanes, then full readback
        for (int i = 0; i < 150; i++) begin
            wr(int'($urandom_range(ROWS - 1, 0)), int'($urandom_range(COLS - 1, 0)),
               EW'($urandom), s0);
            if ($urandom_range(2, 0) != 0) idle(int'($urandom_range(2, 1)));
        end
        idle(3);
        for (int r = 0; r < ROWS; r++) begin
            rd_issue(r, "R10 row isolation");
            tick();
        end
        idle(4);
        chk("R2 all reads returned", WW'(exp_q.size()), WW'(0));

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule